// File: doc/BRIEF.md
# ADC Conversion Slot Scheduler

This block is the digital controller for one shared 12-bit analog-to-digital converter. It holds sixteen conversion slots. Each slot has its own trigger code, analog channel and sample-window length. When a trigger event arrives, every slot mapped to that event becomes pending, so a single event can start a burst of conversions. A round-robin arbiter picks pending slots one at a time. The controller drives the two sample-and-hold paths and the converter handshake. Each 12-bit code is stored in the result register whose index equals the slot that produced it.

Adjacent slot pairs can be switched to simultaneous mode. In that mode both sample-and-hold paths capture at the same instant, and the converter then digitises the two held values back to back. Nine interrupt lines each watch one selectable slot. Each line has a sticky flag and an optional continuous mode. Lines 0 and 1 also feed back into the trigger map, so the end of one burst can start another.

The control core is a four-state machine:
- IDLE waits for a pending slot. On the grant it latches the slot's settings and moves to SAMPLE.
- SAMPLE holds the sample-and-hold strobe for window+1 cycles, then moves to START.
- START pulses the converter start for one cycle and moves to WAIT.
- WAIT stays until the converter returns a code. It then goes back to START for the second half of a simultaneous pair, or to IDLE otherwise.

Top module: `adc_soc_sched`

## Requirements
- R1: A configuration write (`cfg_we`) stores trigger code, channel and window for slot `cfg_slot`. The trigger code map is as follows:
  - 0 and 15: no trigger.
  - 1..8: `trig_ext[0..7]` (PWM events).
  - 9: `trig_ext[8]` (GPIO).
  - 10..12: `trig_ext[9..11]` (timers).
  - 13 and 14: interrupt lines 0 and 1.
  
  `sw_force[i]` makes slot i pending whatever its code. External inputs are single-cycle event pulses.
- R2: One event makes every slot mapped to its code pending, and all of them are converted.
- R3: Pending slots are granted in round-robin order, starting from the slot after the last one written. After reset the search starts at slot 0.
- R4: `sh_sample` stays high for exactly window+1 cycles. `cv_start` is then a single-cycle pulse.
- R5: The code on `cv_code` when `cv_valid` is high is stored in the result register with the slot's index, and is read through `rd_idx`/`rd_data`.
- R6: When `simul_mask[k]` is set and slot 2k or 2k+1 is granted, the granted slot's settings are used and both pending bits clear. Path A samples channel {0,ch[2:0]} and its result goes to slot 2k. Path B samples channel {1,ch[2:0]} and its result goes to slot 2k+1. Path A is converted first.
- R7: Channel, window and pairing are latched at the grant. A configuration write during a conversion affects only later conversions.
- R8: A trigger for a slot that is already pending and not being granted sets that slot's sticky `ovf_flag`. Writing a one to `ovf_clr` clears it.
- R9: An enabled interrupt line pulses `int_pulse` for one cycle after its source slot (`int_src`, 4 bits per line) completes, and sets its sticky flag. While the flag is set, the line does not pulse again unless `int_cont` is set for that line.
- R10: Writing a one to `int_clr` clears that line's flag. A same-cycle set takes priority.
- R11: A pulse on interrupt line 0 or 1 acts as trigger code 13 or 14, making the mapped slots pending.
- R12: After reset the following hold:
  - All results are zero.
  - No slot is pending.
  - No flag is set.
  - The scheduler is idle.
  - Every slot has trigger code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | 4 | Slot being configured |
| cfg_trig | input | 4 | Trigger code for the slot |
| cfg_chan | input | 4 | Analog channel for the slot |
| cfg_win | input | 6 | Sample window (cycles minus one) |
| simul_mask | input | 8 | Simultaneous mode per slot pair |
| sw_force | input | 16 | Software start, one bit per slot |
| trig_ext | input | 12 | PWM, GPIO and timer event pulses |
| ovf_clr | input | 16 | Write-one clear of overflow flags |
| int_en | input | 9 | Interrupt line enables |
| int_cont | input | 9 | Continuous mode per line |
| int_src | input | 36 | Source slot per line, 4 bits each |
| int_clr | input | 9 | Write-one clear of interrupt flags |
| sh_sample | output | 1 | Sample-and-hold capture strobe |
| sh_dual | output | 1 | Both paths capture together |
| sh_ch_a | output | 4 | Channel on path A |
| sh_ch_b | output | 4 | Channel on path B |
| cv_start | output | 1 | Converter start pulse |
| cv_chan | output | 4 | Channel being converted |
| cv_valid | input | 1 | Converter result valid |
| cv_code | input | 12 | Converter result code |
| rd_idx | input | 4 | Result register read index |
| rd_data | output | 12 | Result register read data |
| pend | output | 16 | Pending slot flags |
| ovf_flag | output | 16 | Sticky overflow flags |
| sched_busy | output | 1 | State machine not in IDLE |
| int_pulse | output | 9 | Interrupt request pulses |
| int_flag | output | 9 | Sticky interrupt flags |

## Verification
The bench builds the block with its default parameters:
- sixteen slots;
- a 6-bit window field;
- twelve external event inputs;
- nine interrupt lines.

With a 6-bit window, the longest window of 64 sample cycles can be reached. With sixteen slots, the round-robin search can be made to wrap past slot 15. The converter model answers 13 cycles after each start with a code built from the requested channel, so every stored result shows which channel produced it. The table and directed tests cover chained bursts, arbitration order, overflow, simultaneous pairs, configuration changes in mid-conversion and interrupt loopback.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
    localparam int TRIG_W       = 4;
    localparam int TRIG_CODES   = 2 ** TRIG_W;
    localparam int TRIG_EXT_LO  = 1;
    localparam int TRIG_LOOP0   = 13;
    localparam int TRIG_LOOP1   = 14;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_START  = 2'd2,
        ST_WAIT   = 2'd3
    } sched_st_e;
endpackage

// File: rtl/adc_slot_pend.sv
module adc_slot_pend
    import adc_sched_pkg::*;
#(
    parameter int N_SLOT = 16,
    parameter int CH_W   = 4,
    parameter int WIN_W  = 6,
    parameter int N_EXT  = 12,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [SLOT_W-1:0]              cfg_slot,
    input  logic [TRIG_W-1:0]              cfg_trig,
    input  logic [CH_W-1:0]                cfg_chan,
    input  logic [WIN_W-1:0]               cfg_win,
    input  logic [N_SLOT-1:0]              sw_force,
    input  logic [N_EXT-1:0]               trig_ext,
    input  logic [1:0]                     loop_int,
    input  logic [N_SLOT-1:0]              grant_clr,
    input  logic [N_SLOT-1:0]              ovf_clr,
    output logic [N_SLOT-1:0][CH_W-1:0]    slot_chan,
    output logic [N_SLOT-1:0][WIN_W-1:0]   slot_win,
    output logic [N_SLOT-1:0]              pend_q,
    output logic [N_SLOT-1:0]              ovf_q
);
    logic [N_SLOT-1:0][TRIG_W-1:0] trig_q;
    logic [TRIG_CODES-1:0]         ev;
    logic [N_SLOT-1:0]             set_v;

    always_comb begin
        ev = '0;
        for (int k = 0; k < N_EXT; k++) begin
            if (TRIG_EXT_LO + k < TRIG_LOOP0) ev[TRIG_EXT_LO + k] = trig_ext[k];
        end
        ev[TRIG_LOOP0] = loop_int[0];
        ev[TRIG_LOOP1] = loop_int[1];
    end

    generate
        for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
            assign set_v[i] = sw_force[i] | ev[trig_q[i]];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    trig_q[i]    <= '0;
                    slot_chan[i] <= '0;
                    slot_win[i]  <= '0;
                end else if (cfg_we && cfg_slot == SLOT_W'(i)) begin
                    trig_q[i]    <= cfg_trig;
                    slot_chan[i] <= cfg_chan;
                    slot_win[i]  <= cfg_win;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            ovf_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~grant_clr) | set_v;
            ovf_q  <= (ovf_q & ~ovf_clr) | (set_v & pend_q & ~grant_clr);
        end
    end

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_v & pend_q & ~grant_clr)) |=> (|ovf_q));

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> (|pend_q));
endmodule

// File: rtl/adc_rr_pick.sv
module adc_rr_pick #(
    parameter int N_SLOT = 16,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic [N_SLOT-1:0] pend,
    input  logic [SLOT_W-1:0] last,
    output logic              any,
    output logic [SLOT_W-1:0] pick
);
    logic [SLOT_W-1:0] idx_v;
    logic              found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        idx_v = '0;
        any   = |pend;
        for (int k = 1; k <= N_SLOT; k++) begin
            idx_v = SLOT_W'((int'(last) + k) % N_SLOT);
            if (!found && pend[idx_v]) begin
                pick  = idx_v;
                found = 1'b1;
            end
        end
    end

    // R3
    always_comb begin
        pick_pend_chk: assert (!any || pend[pick]);
    end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_sched_pkg::*;
#(
    parameter int N_SLOT = 16,
    parameter int CH_W   = 4,
    parameter int WIN_W  = 6,
    parameter int CODE_W = 12,
    localparam int SLOT_W = $clog2(N_SLOT),
    localparam int N_PAIR = N_SLOT / 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          any_pend,
    input  logic [SLOT_W-1:0]             pick,
    input  logic [N_SLOT-1:0][CH_W-1:0]   slot_chan,
    input  logic [N_SLOT-1:0][WIN_W-1:0]  slot_win,
    input  logic [N_PAIR-1:0]             simul_mask,
    output logic [N_SLOT-1:0]             grant_clr,
    output logic [SLOT_W-1:0]             last_slot,
    input  logic                          cv_valid,
    input  logic [CODE_W-1:0]             cv_code,
    output logic                          sh_sample,
    output logic                          sh_dual,
    output logic [CH_W-1:0]               sh_ch_a,
    output logic [CH_W-1:0]               sh_ch_b,
    output logic                          cv_start,
    output logic [CH_W-1:0]               cv_chan,
    output logic                          busy,
    output logic [N_SLOT-1:0]             done_vec,
    input  logic [SLOT_W-1:0]             rd_idx,
    output logic [CODE_W-1:0]             rd_data
);
    sched_st_e          state_q, state_d;
    logic [SLOT_W-1:0]  cur_q;
    logic [CH_W-1:0]    chan_q;
    logic [WIN_W-1:0]   win_q;
    logic [WIN_W-1:0]   cnt_q;
    logic               dual_q;
    logic               path_b_q;
    logic [SLOT_W-1:0]  res_idx;
    logic               grant;
    logic               pick_dual;
    logic [CODE_W-1:0]  res_q [N_SLOT];

    assign grant     = (state_q == ST_IDLE) && any_pend;
    assign pick_dual = simul_mask[pick[SLOT_W-1:1]];
    assign res_idx   = dual_q ? {cur_q[SLOT_W-1:1], path_b_q} : cur_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_pend) state_d = ST_SAMPLE;
            ST_SAMPLE: if (cnt_q == win_q) state_d = ST_START;
            ST_START:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (cv_valid) state_d = (dual_q && !path_b_q) ? ST_START : ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            chan_q    <= '0;
            win_q     <= '0;
            cnt_q     <= '0;
            dual_q    <= 1'b0;
            path_b_q  <= 1'b0;
            last_slot <= SLOT_W'(N_SLOT - 1);
            done_vec  <= '0;
            for (int i = 0; i < N_SLOT; i++) res_q[i] <= '0;
        end else begin
            done_vec <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (any_pend) begin
                        cur_q    <= pick;
                        chan_q   <= slot_chan[pick];
                        win_q    <= slot_win[pick];
                        dual_q   <= pick_dual;
                        path_b_q <= 1'b0;
                        cnt_q    <= '0;
                    end
                end
                ST_SAMPLE: cnt_q <= cnt_q + 1'b1;
                ST_START:  ;
                ST_WAIT: begin
                    if (cv_valid) begin
                        res_q[res_idx]    <= cv_code;
                        done_vec[res_idx] <= 1'b1;
                        if (dual_q && !path_b_q) path_b_q <= 1'b1;
                        else                     last_slot <= res_idx;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        grant_clr = '0;
        if (grant) begin
            if (pick_dual) begin
                grant_clr[{pick[SLOT_W-1:1], 1'b0}] = 1'b1;
                grant_clr[{pick[SLOT_W-1:1], 1'b1}] = 1'b1;
            end else begin
                grant_clr[pick] = 1'b1;
            end
        end
        sh_sample = (state_q == ST_SAMPLE);
        sh_dual   = sh_sample && dual_q;
        sh_ch_a   = dual_q ? {1'b0, chan_q[CH_W-2:0]} : chan_q;
        sh_ch_b   = {1'b1, chan_q[CH_W-2:0]};
        cv_start  = (state_q == ST_START);
        cv_chan   = dual_q ? {path_b_q, chan_q[CH_W-2:0]} : chan_q;
        busy      = (state_q != ST_IDLE);
        rd_data   = res_q[rd_idx];
    end

    logic [WIN_W:0] len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         len_q <= '0;
        else if (sh_sample) len_q <= len_q + 1'b1;
        else                len_q <= '0;
    end

    // R4
    sample_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_sample) |-> (len_q == {1'b0, win_q} + 1'b1));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |=> !cv_start);

    // R5
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));
endmodule

// File: rtl/adc_irq_lines.sv
module adc_irq_lines #(
    parameter int N_SLOT = 16,
    parameter int N_IRQ  = 9,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SLOT-1:0]         done_vec,
    input  logic [N_IRQ-1:0]          int_en,
    input  logic [N_IRQ-1:0]          int_cont,
    input  logic [N_IRQ*SLOT_W-1:0]   int_src,
    input  logic [N_IRQ-1:0]          int_clr,
    output logic [N_IRQ-1:0]          int_pulse,
    output logic [N_IRQ-1:0]          int_flag
);
    generate
        for (genvar j = 0; j < N_IRQ; j++) begin : g_line
            logic fire;
            assign fire = int_en[j] && done_vec[int_src[j*SLOT_W +: SLOT_W]]
                          && (!int_flag[j] || int_cont[j]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    int_pulse[j] <= 1'b0;
                    int_flag[j]  <= 1'b0;
                end else begin
                    int_pulse[j] <= fire;
                    int_flag[j]  <= (int_flag[j] && !int_clr[j]) || fire;
                end
            end

            // R9
            flag_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                int_pulse[j] |-> int_flag[j]);

            // R9
            quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (int_flag[j] && !int_cont[j]) |=> !int_pulse[j]);
        end
    endgenerate
endmodule

// File: rtl/adc_soc_sched.sv
module adc_soc_sched
    import adc_sched_pkg::*;
#(
    parameter int N_SLOT = 16,
    parameter int CH_W   = 4,
    parameter int WIN_W  = 6,
    parameter int CODE_W = 12,
    parameter int N_EXT  = 12,
    parameter int N_IRQ  = 9,
    localparam int SLOT_W = $clog2(N_SLOT),
    localparam int N_PAIR = N_SLOT / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [SLOT_W-1:0]        cfg_slot,
    input  logic [TRIG_W-1:0]        cfg_trig,
    input  logic [CH_W-1:0]          cfg_chan,
    input  logic [WIN_W-1:0]         cfg_win,
    input  logic [N_PAIR-1:0]        simul_mask,
    input  logic [N_SLOT-1:0]        sw_force,
    input  logic [N_EXT-1:0]         trig_ext,
    input  logic [N_SLOT-1:0]        ovf_clr,
    input  logic [N_IRQ-1:0]         int_en,
    input  logic [N_IRQ-1:0]         int_cont,
    input  logic [N_IRQ*SLOT_W-1:0]  int_src,
    input  logic [N_IRQ-1:0]         int_clr,
    output logic                     sh_sample,
    output logic                     sh_dual,
    output logic [CH_W-1:0]          sh_ch_a,
    output logic [CH_W-1:0]          sh_ch_b,
    output logic                     cv_start,
    output logic [CH_W-1:0]          cv_chan,
    input  logic                     cv_valid,
    input  logic [CODE_W-1:0]        cv_code,
    input  logic [SLOT_W-1:0]        rd_idx,
    output logic [CODE_W-1:0]        rd_data,
    output logic [N_SLOT-1:0]        pend,
    output logic [N_SLOT-1:0]        ovf_flag,
    output logic                     sched_busy,
    output logic [N_IRQ-1:0]         int_pulse,
    output logic [N_IRQ-1:0]         int_flag
);
    logic [N_SLOT-1:0][CH_W-1:0]  slot_chan;
    logic [N_SLOT-1:0][WIN_W-1:0] slot_win;
    logic [N_SLOT-1:0]            grant_clr;
    logic [N_SLOT-1:0]            done_vec;
    logic [SLOT_W-1:0]            last_slot;
    logic [SLOT_W-1:0]            pick;
    logic                         any_pend;

    adc_slot_pend #(.N_SLOT(N_SLOT), .CH_W(CH_W), .WIN_W(WIN_W), .N_EXT(N_EXT)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_trig(cfg_trig),
        .cfg_chan(cfg_chan), .cfg_win(cfg_win),
        .sw_force(sw_force), .trig_ext(trig_ext), .loop_int(int_pulse[1:0]),
        .grant_clr(grant_clr), .ovf_clr(ovf_clr),
        .slot_chan(slot_chan), .slot_win(slot_win),
        .pend_q(pend), .ovf_q(ovf_flag)
    );

    adc_rr_pick #(.N_SLOT(N_SLOT)) u_pick (
        .pend(pend), .last(last_slot), .any(any_pend), .pick(pick)
    );

    adc_conv_ctrl #(.N_SLOT(N_SLOT), .CH_W(CH_W), .WIN_W(WIN_W), .CODE_W(CODE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .any_pend(any_pend), .pick(pick),
        .slot_chan(slot_chan), .slot_win(slot_win), .simul_mask(simul_mask),
        .grant_clr(grant_clr), .last_slot(last_slot),
        .cv_valid(cv_valid), .cv_code(cv_code),
        .sh_sample(sh_sample), .sh_dual(sh_dual), .sh_ch_a(sh_ch_a), .sh_ch_b(sh_ch_b),
        .cv_start(cv_start), .cv_chan(cv_chan), .busy(sched_busy),
        .done_vec(done_vec), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    adc_irq_lines #(.N_SLOT(N_SLOT), .N_IRQ(N_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .done_vec(done_vec),
        .int_en(int_en), .int_cont(int_cont), .int_src(int_src), .int_clr(int_clr),
        .int_pulse(int_pulse), .int_flag(int_flag)
    );

    // R11
    loop_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse[0] |-> $past(int_en[0]));
endmodule

// File: tb/adc_soc_sched_tb_top.sv
module adc_soc_sched_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        cfg_we = 0;
    logic [3:0]  cfg_slot = 0, cfg_trig = 0, cfg_chan = 0;
    logic [5:0]  cfg_win = 0;
    logic [7:0]  simul_mask = 0;
    logic [15:0] sw_force = 0, ovf_clr = 0;
    logic [11:0] trig_ext = 0;
    logic [8:0]  int_en = 0, int_cont = 0, int_clr = 0;
    logic [35:0] int_src = 0;
    logic        sh_sample, sh_dual, cv_start, sched_busy;
    logic [3:0]  sh_ch_a, sh_ch_b, cv_chan;
    logic        cv_valid = 0;
    logic [11:0] cv_code = 0;
    logic [3:0]  rd_idx = 0;
    logic [11:0] rd_data;
    logic [15:0] pend, ovf_flag;
    logic [8:0]  int_pulse, int_flag;

    adc_soc_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_trig(cfg_trig), .cfg_chan(cfg_chan), .cfg_win(cfg_win),
        .simul_mask(simul_mask), .sw_force(sw_force), .trig_ext(trig_ext),
        .ovf_clr(ovf_clr), .int_en(int_en), .int_cont(int_cont), .int_src(int_src),
        .int_clr(int_clr), .sh_sample(sh_sample), .sh_dual(sh_dual),
        .sh_ch_a(sh_ch_a), .sh_ch_b(sh_ch_b), .cv_start(cv_start), .cv_chan(cv_chan),
        .cv_valid(cv_valid), .cv_code(cv_code), .rd_idx(rd_idx), .rd_data(rd_data),
        .pend(pend), .ovf_flag(ovf_flag), .sched_busy(sched_busy),
        .int_pulse(int_pulse), .int_flag(int_flag)
    );

    int errors = 0, checks = 0, cycles = 0;
    int cv_cnt = 0, samp_cnt = 0, n_log = 0;
    int p_cnt [9];
    logic [3:0] cv_ch_l;
    logic [3:0] log_ch [8];

    function automatic logic [11:0] code_of(input logic [3:0] ch);
        return {ch, 8'h3C};
    endfunction

    // converter model, sample-length and interrupt monitors
    initial for (int j = 0; j < 9; j++) p_cnt[j] = 0;
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (sh_sample) samp_cnt <= samp_cnt + 1;
        for (int j = 0; j < 9; j++) if (int_pulse[j]) p_cnt[j] <= p_cnt[j] + 1;
        cv_valid <= 1'b0;
        if (cv_start) begin
            cv_cnt  <= 13;
            cv_ch_l <= cv_chan;
            if (n_log < 8) begin
                log_ch[n_log] <= cv_chan;
                n_log <= n_log + 1;
            end
        end else if (cv_cnt > 0) begin
            cv_cnt <= cv_cnt - 1;
            if (cv_cnt == 1) begin
                cv_valid <= 1'b1;
                cv_code  <= code_of(cv_ch_l);
            end
        end
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL R12 watchdog expired act=%0d exp<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int s, input int t, input int c, input int w);
        @(negedge clk);
        cfg_we = 1; cfg_slot = 4'(s); cfg_trig = 4'(t); cfg_chan = 4'(c); cfg_win = 6'(w);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic force_slots(input logic [15:0] m);
        @(negedge clk); sw_force = m;
        @(negedge clk); sw_force = 0;
    endtask

    task automatic pulse_ext(input int code);
        @(negedge clk); trig_ext[code-1] = 1'b1;
        @(negedge clk); trig_ext = 0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (!sched_busy && pend == 0 && cv_cnt == 0) quiet++; else quiet = 0;
            if (quiet >= 6) break;
        end
    endtask

    task automatic rd(input int idx, output logic [11:0] v);
        rd_idx = 4'(idx); #1; v = rd_data;
    endtask

    // slot, trigger code, channel, window
    localparam logic [17:0] VEC [6] = '{
        {4'd0,  4'd1,  4'd5,  6'd0},
        {4'd7,  4'd4,  4'd9,  6'd3},
        {4'd13, 4'd9,  4'd15, 6'd10},
        {4'd6,  4'd10, 4'd0,  6'd1},
        {4'd15, 4'd12, 4'd12, 6'd63},
        {4'd4,  4'd8,  4'd2,  6'd5}
    };

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(pend == 0 && !sched_busy, "R12 idle", {pend, 15'd0, sched_busy}, 0);
        chk(int_flag == 0 && ovf_flag == 0, "R12 flags", {int_flag, ovf_flag}, 0);
        for (int i = 0; i < 16; i++) begin
            rd(i, v); chk(v == 0, "R12 result", v, 0);
        end

        // R1 R4 R5 table of single-slot conversions
        for (int n = 0; n < 6; n++) begin
            cfg(VEC[n][17:14], VEC[n][13:10], VEC[n][9:6], VEC[n][5:0]);
            samp_cnt = 0;
            pulse_ext(VEC[n][13:10]);
            wait_idle();
            rd(VEC[n][17:14], v);
            chk(v == code_of(VEC[n][9:6]), "R5 result", v, code_of(VEC[n][9:6]));
            chk(samp_cnt == VEC[n][5:0] + 1, "R4 sample len", samp_cnt, VEC[n][5:0] + 1);
        end

        // R2 R3 chain from one event; last slot 4 so order 5,9,3
        cfg(3, 2, 3, 0); cfg(5, 2, 5, 0); cfg(9, 2, 9, 0);
        n_log = 0;
        pulse_ext(2);
        wait_idle();
        chk(n_log == 3, "R2 chain count", n_log, 3);
        chk(log_ch[0] == 5 && log_ch[1] == 9 && log_ch[2] == 3, "R3 wrap order",
            {log_ch[0], log_ch[1], log_ch[2]}, 12'h593);
        rd(9, v); chk(v == code_of(9), "R2 chain result", v, code_of(9));

        // R3 slots 2 and 12 together, last was 3 -> 12 first
        cfg(2, 0, 1, 0); cfg(12, 0, 8, 0);
        n_log = 0;
        force_slots(16'h1004);
        wait_idle();
        chk(log_ch[0] == 8 && log_ch[1] == 1, "R3 rr order", {log_ch[0], log_ch[1]}, 8'h81);

        // R8 overflow
        cfg(7, 0, 9, 40); cfg(8, 0, 1, 0);
        @(negedge clk); sw_force = 16'h0080;
        @(negedge clk); sw_force = 16'h0100;
        @(negedge clk); sw_force = 16'h0100;
        @(negedge clk); sw_force = 0;
        chk(ovf_flag[8] && !ovf_flag[7], "R8 overflow", ovf_flag, 16'h0100);
        wait_idle();
        @(negedge clk); ovf_clr = 16'h0100;
        @(negedge clk); ovf_clr = 0;
        chk(ovf_flag == 0, "R8 clear", ovf_flag, 0);

        // R7 configuration change during conversion
        cfg(11, 0, 2, 20);
        samp_cnt = 0;
        force_slots(16'h0800);
        repeat (4) @(negedge clk);
        chk(sh_sample == 1'b1, "R7 in sample", sh_sample, 1);
        cfg(11, 0, 6, 1);
        wait_idle();
        rd(11, v); chk(v == code_of(2), "R7 latched chan", v, code_of(2));
        chk(samp_cnt == 21, "R7 latched win", samp_cnt, 21);
        samp_cnt = 0;
        force_slots(16'h0800);
        wait_idle();
        rd(11, v); chk(v == code_of(6), "R7 new chan", v, code_of(6));
        chk(samp_cnt == 2, "R7 new win", samp_cnt, 2);

        // R6 simultaneous pair (4,5), chan 11 -> A=3, B=11
        cfg(4, 0, 11, 2);
        simul_mask = 8'h04;
        n_log = 0;
        force_slots(16'h0010);
        wait_idle();
        simul_mask = 0;
        rd(4, v); chk(v == code_of(3), "R6 path A", v, code_of(3));
        rd(5, v); chk(v == code_of(11), "R6 path B", v, code_of(11));
        chk(n_log == 2 && log_ch[0] == 3, "R6 order", {n_log[3:0], log_ch[0]}, 8'h23);

        // R9 R10 sticky and continuous lines on slot 6
        int_src[2*4 +: 4] = 4'd6; int_src[3*4 +: 4] = 4'd6;
        int_en[2] = 1; int_en[3] = 1; int_cont[3] = 1;
        force_slots(16'h0040); wait_idle();
        force_slots(16'h0040); wait_idle();
        chk(p_cnt[2] == 1, "R9 sticky blocks", p_cnt[2], 1);
        chk(p_cnt[3] == 2, "R9 continuous", p_cnt[3], 2);
        chk(int_flag[2] == 1, "R9 flag set", int_flag[2], 1);
        @(negedge clk); int_clr = 9'h004;
        @(negedge clk); int_clr = 0;
        chk(int_flag[2] == 0 && int_flag[3] == 1, "R10 clear", int_flag, 9'h008);

        // R11 loopback of line 0 into trigger code 13
        int_src[3:0] = 4'd1; int_en[0] = 1;
        cfg(1, 0, 7, 0); cfg(10, 13, 14, 0);
        force_slots(16'h0002);
        wait_idle();
        rd(1, v);  chk(v == code_of(7), "R11 source", v, code_of(7));
        rd(10, v); chk(v == code_of(14), "R11 looped", v, code_of(14));
        chk(int_flag[0] == 1, "R11 flag", int_flag[0], 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule